// File: doc/BRIEF.md
# Tick-Driven Interval Timer Bank

This block holds a bank of interval timers. There is one timer for each processor and one shared system timer. Each timer keeps a free-running count and a limit, and both can be read over a small register bus. A one-microsecond tick input advances every counting timer by one. When a timer's count reaches its period, the counter restarts and the timer raises its interrupt. The interrupt stays asserted until software reads that timer's limit register. The system timer's interrupt is meant for interrupt level 10, and each processor's interrupt is meant for level 14. Routing those lines to processors happens outside this block.

The count and the limit use the upper part of a 32-bit word, from bit 10 up to bit 30. To get a period of P ticks, software writes (P + 1) shifted left by 10 into the limit register. Bit 31 of a read value reports that the limit has been reached. A limit of zero parks the timer, which is how software silences a processor timer. Each processor's timer sits on its own 4 KiB page. The system timer has a page of its own placed after them.

Top module: `ivt_bank`

## Requirements
- R1: After reset every limit is 0, every count reads 0x0000_0400 (count 1), and `irq_sys` and all `irq_cpu` bits are low.
- R2: Address bits [15:12] select a page: processor timer i uses page i, and the system timer uses page NUM_CPU (4). Within a page, address bit 2 selects the register: 0 selects the limit and 1 selects the count. A read of any other page returns 0. `bus_rdata` shows the selected word on the clock edge that samples `bus_rd`.
- R3: A limit write keeps only `bus_wdata[30:10]`. Every read returns bits [9:0] as zero. A read word is {flag, field[20:0], 10'b0}.
- R4: While the limit is non-zero, each cycle with `tick_us` high raises the count by one. The count does not change in cycles without a tick.
- R5: With a limit field L of 2 or more, counting from 1, the L-1th tick fires the timer and reloads the count to 1. A limit field of 1 fires on every tick.
- R6: A firing sets the flag, which is bit 31 of both of that timer's read words. It also drives the timer's interrupt: `irq_sys` for the system timer and `irq_cpu[i]` for processor i. The interrupt stays high until it is acknowledged.
- R7: A read of a timer's limit register clears its flag, and the interrupt is low from the next cycle. A read of the count register does not clear it. If the timer fires in the same cycle as the limit read, the flag stays set.
- R8: A limit write resets that timer's count to 1 and suppresses a firing in that cycle.
- R9: With a limit of 0 the count holds and the timer never fires.
- R10: Writes to a count register are ignored. Timers do not affect one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-cycle microsecond advance pulse |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_sys | output | 1 | System timer interrupt (level 10) |
| irq_cpu | output | 4 | Per-processor timer interrupts (level 14) |

## Verification
The assertions check the following on every cycle for every timer:
- an interrupt holds until its limit register is read;
- an interrupt rises only in a cycle that carries a tick;
- a limit read without a tick drops the interrupt;
- a limit write never fires;
- read data keeps bits [9:0] at zero.

Only the bench scenarios can show the exact period length in ticks, the reload value, the parked behaviour of a zero limit over many ticks, and the case where a firing collides with an acknowledge.

// File: rtl/ivt_pkg.sv
`timescale 1ns/1ps
package ivt_pkg;
   // register selected by address bit 2 inside a timer page
   typedef enum logic {
      SEL_LIMIT = 1'b0,
      SEL_COUNT = 1'b1
   } ivt_sel_e;

   // byte-address bit that picks the register inside a page
   localparam int unsigned SEL_BIT = 2;
endpackage

// File: rtl/ivt_timer.sv
`timescale 1ns/1ps
module ivt_timer #(
   parameter int unsigned CNT_W = 21
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             lim_wr,
   input  logic [CNT_W-1:0] lim_wdata,
   input  logic             lim_rd,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] limit_o,
   output logic             flag_o
);
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] limit_q;
   logic             flag_q;
   logic [CNT_W:0]   next_cnt;
   logic             running;
   logic             reach;
   logic             fire;

   assign next_cnt = {1'b0, count_q} + {{CNT_W{1'b0}}, 1'b1};
   assign running  = (limit_q != '0);
   assign reach    = (next_cnt >= {1'b0, limit_q});
   assign fire     = tick && running && reach && !lim_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= {{(CNT_W-1){1'b0}}, 1'b1};
         limit_q <= '0;
      end else if (lim_wr) begin
         limit_q <= lim_wdata;
         count_q <= {{(CNT_W-1){1'b0}}, 1'b1};
      end else if (tick && running) begin
         if (reach) count_q <= {{(CNT_W-1){1'b0}}, 1'b1};
         else       count_q <= next_cnt[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (fire)   flag_q <= 1'b1;
      else if (lim_rd) flag_q <= 1'b0;
   end

   assign count_o = count_q;
   assign limit_o = limit_q;
   assign flag_o  = flag_q;
endmodule

// File: rtl/ivt_decode.sv
`timescale 1ns/1ps
module ivt_decode
   import ivt_pkg::*;
#(
   parameter int unsigned NUM_TMR    = 5,
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned PAGE_SHIFT = 12
) (
   input  logic                bus_rd,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   output logic [NUM_TMR-1:0]  page_hit,
   output logic [NUM_TMR-1:0]  lim_wr,
   output logic [NUM_TMR-1:0]  lim_rd,
   output ivt_sel_e            sel
);
   localparam int unsigned PAGE_W = ADDR_W - PAGE_SHIFT;

   logic [PAGE_W-1:0] page;
   assign page = bus_addr[ADDR_W-1:PAGE_SHIFT];
   assign sel  = ivt_sel_e'(bus_addr[SEL_BIT]);

   for (genvar i = 0; i < NUM_TMR; i++) begin : g_hit
      localparam logic [PAGE_W-1:0] PG = PAGE_W'(i);
      assign page_hit[i] = (page == PG);
      assign lim_wr[i]   = bus_wr && page_hit[i] && (sel == SEL_LIMIT);
      assign lim_rd[i]   = bus_rd && page_hit[i] && (sel == SEL_LIMIT);
   end
endmodule

// File: rtl/ivt_readback.sv
`timescale 1ns/1ps
module ivt_readback
   import ivt_pkg::*;
#(
   parameter int unsigned NUM_TMR   = 5,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned FIELD_LSB = 10,
   parameter int unsigned CNT_W     = 21
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          bus_rd,
   input  ivt_sel_e                      sel,
   input  logic [NUM_TMR-1:0]            page_hit,
   input  logic [NUM_TMR-1:0][CNT_W-1:0] counts,
   input  logic [NUM_TMR-1:0][CNT_W-1:0] limits,
   input  logic [NUM_TMR-1:0]            flags,
   output logic [DATA_W-1:0]             rdata
);
   logic [NUM_TMR-1:0][DATA_W-1:0] words;
   logic [DATA_W-1:0]              merged;

   for (genvar i = 0; i < NUM_TMR; i++) begin : g_word
      logic [CNT_W-1:0] field;
      assign field    = (sel == SEL_COUNT) ? counts[i] : limits[i];
      assign words[i] = page_hit[i] ? {flags[i], field, {FIELD_LSB{1'b0}}} : '0;
   end

   always_comb begin
      merged = '0;
      for (int i = 0; i < NUM_TMR; i++) merged = merged | words[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      rdata <= '0;
      else if (bus_rd) rdata <= merged;
   end
endmodule

// File: rtl/ivt_bank.sv
`timescale 1ns/1ps
module ivt_bank
   import ivt_pkg::*;
#(
   parameter int unsigned NUM_CPU    = 4,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned FIELD_LSB  = 10,
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned PAGE_SHIFT = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_us,
   input  logic               bus_rd,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               irq_sys,
   output logic [NUM_CPU-1:0] irq_cpu
);
   localparam int unsigned NUM_TMR = NUM_CPU + 1;
   localparam int unsigned SYS_IDX = NUM_CPU;
   localparam int unsigned CNT_W   = DATA_W - 1 - FIELD_LSB;
   localparam int unsigned PAGE_W  = ADDR_W - PAGE_SHIFT;

   if (NUM_CPU < 1) begin : g_bad_cpu
      $error("ivt_bank: NUM_CPU must be at least 1");
   end
   if (CNT_W < 2) begin : g_bad_field
      $error("ivt_bank: DATA_W leaves too few count bits above FIELD_LSB");
   end
   if (PAGE_SHIFT <= SEL_BIT || PAGE_SHIFT >= ADDR_W) begin : g_bad_page
      $error("ivt_bank: PAGE_SHIFT out of range");
   end
   if (NUM_TMR > (1 << PAGE_W)) begin : g_bad_map
      $error("ivt_bank: address space too small for all timer pages");
   end

   logic [NUM_TMR-1:0]            page_hit;
   logic [NUM_TMR-1:0]            lim_wr;
   logic [NUM_TMR-1:0]            lim_rd;
   ivt_sel_e                      sel;
   logic [NUM_TMR-1:0][CNT_W-1:0] counts;
   logic [NUM_TMR-1:0][CNT_W-1:0] limits;
   logic [NUM_TMR-1:0]            flags;

   ivt_decode #(
      .NUM_TMR    (NUM_TMR),
      .ADDR_W     (ADDR_W),
      .PAGE_SHIFT (PAGE_SHIFT)
   ) u_decode (
      .bus_rd   (bus_rd),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .page_hit (page_hit),
      .lim_wr   (lim_wr),
      .lim_rd   (lim_rd),
      .sel      (sel)
   );

   for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
      ivt_timer #(.CNT_W(CNT_W)) u_timer (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick      (tick_us),
         .lim_wr    (lim_wr[i]),
         .lim_wdata (bus_wdata[DATA_W-2:FIELD_LSB]),
         .lim_rd    (lim_rd[i]),
         .count_o   (counts[i]),
         .limit_o   (limits[i]),
         .flag_o    (flags[i])
      );
   end

   ivt_readback #(
      .NUM_TMR   (NUM_TMR),
      .DATA_W    (DATA_W),
      .FIELD_LSB (FIELD_LSB),
      .CNT_W     (CNT_W)
   ) u_readback (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_rd   (bus_rd),
      .sel      (sel),
      .page_hit (page_hit),
      .counts   (counts),
      .limits   (limits),
      .flags    (flags),
      .rdata    (bus_rdata)
   );

   assign irq_sys = flags[SYS_IDX];
   assign irq_cpu = flags[NUM_CPU-1:0];
endmodule

// File: rtl/ivt_bank_chk.sv
`timescale 1ns/1ps
module ivt_bank_chk #(
   parameter int unsigned NUM_CPU    = 4,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned FIELD_LSB  = 10,
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned PAGE_SHIFT = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic               tick_us,
   input logic               bus_rd,
   input logic               bus_wr,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [DATA_W-1:0]  bus_rdata,
   input logic               irq_sys,
   input logic [NUM_CPU-1:0] irq_cpu
);
   localparam int unsigned NUM_TMR = NUM_CPU + 1;
   localparam int unsigned PAGE_W  = ADDR_W - PAGE_SHIFT;

   logic [NUM_TMR-1:0] irq_all;
   assign irq_all = {irq_sys, irq_cpu};

   AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> (bus_rdata[FIELD_LSB-1:0] == '0));  // R3

   for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
      localparam logic [PAGE_W-1:0] PG = PAGE_W'(i);
      logic ack_i;
      logic wr_i;
      assign ack_i = bus_rd && (bus_addr[ADDR_W-1:PAGE_SHIFT] == PG) && !bus_addr[2];
      assign wr_i  = bus_wr && (bus_addr[ADDR_W-1:PAGE_SHIFT] == PG) && !bus_addr[2];

      AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_all[i] && !ack_i) |=> irq_all[i]);  // R6
      AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
         (!irq_all[i] && !tick_us) |=> !irq_all[i]);  // R6
      AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_i && !tick_us) |=> !irq_all[i]);  // R7
      AST_WRITE_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_i && !irq_all[i]) |=> !irq_all[i]);  // R8
   end
endmodule

bind ivt_bank ivt_bank_chk #(
   .NUM_CPU    (NUM_CPU),
   .DATA_W     (DATA_W),
   .FIELD_LSB  (FIELD_LSB),
   .ADDR_W     (ADDR_W),
   .PAGE_SHIFT (PAGE_SHIFT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_us   (tick_us),
   .bus_rd    (bus_rd),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .irq_sys   (irq_sys),
   .irq_cpu   (irq_cpu)
);

// File: tb/ivt_bank_tb.sv
`timescale 1ns/1ps
module ivt_bank_tb;
   localparam int NCPU = 4;
   localparam int NTMR = NCPU + 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_us = 1'b0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_sys;
   logic [3:0]  irq_cpu;

   int checks = 0;
   int errors = 0;

   int m_cnt  [NTMR];
   int m_lim  [NTMR];
   bit m_flag [NTMR];

   always #5 clk = ~clk;

   ivt_bank u_dut (
      .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_sys(irq_sys), .irq_cpu(irq_cpu)
   );

   function automatic logic [15:0] addr_of(int idx, bit cnt);
      return 16'((idx << 12) | (cnt ? 4 : 0));
   endfunction

   function automatic logic [31:0] exp_word(logic [15:0] a);
      int pg = int'(a[15:12]);
      if (pg >= NTMR) return 32'h0;
      if (a[2]) return {m_flag[pg], 21'(m_cnt[pg]), 10'h0};
      return {m_flag[pg], 21'(m_lim[pg]), 10'h0};
   endfunction

   function automatic bit irq_of(int idx);
      return (idx == NCPU) ? irq_sys : irq_cpu[idx];
   endfunction

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_irqs(string req);
      for (int i = 0; i < NTMR; i++)
         check(irq_of(i) == m_flag[i], req, 32'(irq_of(i)), 32'(m_flag[i]));
   endtask

   // one bus/tick cycle with model update; inputs change at negedge
   task automatic cyc(bit tk, bit rd, bit wr, logic [15:0] a, logic [31:0] wd,
                      string req, bit chk_rd);
      logic [31:0] er;
      int pg;
      er = exp_word(a);
      pg = int'(a[15:12]);
      tick_us = tk; bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
      @(negedge clk);
      tick_us = 0; bus_rd = 0; bus_wr = 0;
      for (int i = 0; i < NTMR; i++) begin
         bit fire = 0;
         bit hit_lim = (pg == i) && !a[2];
         if (wr && hit_lim) begin
            m_lim[i] = int'(wd[30:10]);
            m_cnt[i] = 1;
         end else if (tk && m_lim[i] != 0) begin
            if (m_cnt[i] + 1 >= m_lim[i]) begin m_cnt[i] = 1; fire = 1; end
            else m_cnt[i] = m_cnt[i] + 1;
         end
         if (fire) m_flag[i] = 1;
         else if (rd && hit_lim) m_flag[i] = 0;
      end
      if (rd && chk_rd) check(bus_rdata == er, req, bus_rdata, er);
   endtask

   task automatic tick_n(int n);
      for (int k = 0; k < n; k++) cyc(1, 0, 0, 16'h0, 32'h0, "", 0);
   endtask

   task automatic rd(logic [15:0] a, string req);
      cyc(0, 1, 0, a, 32'h0, req, 1);
   endtask

   task automatic wr(logic [15:0] a, logic [31:0] d);
      cyc(0, 0, 1, a, d, "", 0);
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < NTMR; i++) begin m_cnt[i] = 1; m_lim[i] = 0; m_flag[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check_irqs("R1");
      for (int i = 0; i < NTMR; i++) begin
         rd(addr_of(i, 1), "R1 count");
         rd(addr_of(i, 0), "R1 limit");
      end
      // R2: unmapped pages read zero
      rd(16'h7000, "R2 unmapped");
      rd(16'hF004, "R2 unmapped");

      // R9: zero limit holds
      tick_n(40);
      check_irqs("R9");
      rd(addr_of(2, 1), "R9 count holds");

      // R5: period on cpu1 of 5 ticks, limit written as (5+1)<<10 with junk low bits
      wr(addr_of(1, 0), (32'd6 << 10) | 32'h8000_03FF);
      rd(addr_of(1, 0), "R3 limit field only");
      tick_n(4);
      check(irq_cpu[1] == 1'b0, "R5 no fire before period", 32'(irq_cpu[1]), 32'h0);
      rd(addr_of(1, 1), "R4 count advanced");
      tick_n(1);
      check(irq_cpu[1] == 1'b1, "R5 fire on period", 32'(irq_cpu[1]), 32'h1);
      rd(addr_of(1, 1), "R5 reload and R6 flag in count");
      check(irq_cpu[1] == 1'b1, "R7 count read keeps irq", 32'(irq_cpu[1]), 32'h1);
      rd(addr_of(1, 0), "R6 flag in limit");
      check(irq_cpu[1] == 1'b0, "R7 limit read clears", 32'(irq_cpu[1]), 32'h0);
      check_irqs("R10 independence");

      // R10: count write ignored
      wr(addr_of(1, 1), 32'h1234_5400);
      rd(addr_of(1, 1), "R10 count write ignored");

      // R8: limit write restarts count
      tick_n(2);
      wr(addr_of(1, 0), 32'd6 << 10);
      rd(addr_of(1, 1), "R8 count reset");

      // R5 limit field 1 fires every tick; R7 collision keeps flag
      wr(addr_of(NCPU, 0), 32'd1 << 10);
      tick_n(1);
      check(irq_sys == 1'b1, "R5 limit one fires", 32'(irq_sys), 32'h1);
      cyc(1, 1, 0, addr_of(NCPU, 0), 32'h0, "R7 collision read", 1);
      check(irq_sys == 1'b1, "R7 fire wins over ack", 32'(irq_sys), 32'h1);
      rd(addr_of(NCPU, 0), "R7 ack");
      check(irq_sys == 1'b0, "R7 ack clears", 32'(irq_sys), 32'h0);

      // R9: stop a timer with zero
      wr(addr_of(1, 0), 32'h0);
      tick_n(30);
      check(irq_cpu[1] == 1'b0, "R9 zero never fires", 32'(irq_cpu[1]), 32'h0);

      // random mix
      for (int n = 0; n < 3000; n++) begin
         int kind = int'($urandom % 8);
         int idx  = int'($urandom % 7);
         logic [15:0] a = addr_of(idx, 1'($urandom));
         logic [31:0] d = {1'($urandom), 21'($urandom % 9), 10'($urandom)};
         if (kind < 4)       cyc(1, 0, 0, a, d, "", 0);
         else if (kind < 6)  cyc(1'($urandom), 1, 0, a, d, "R2 R4 R6 random read", 1);
         else if (kind == 6) cyc(1'($urandom), 0, 1, a, d, "", 0);
         else                cyc(1'($urandom), 1, 1, a, d, "R3 R8 random rd+wr", 1);
         check_irqs("R6 R7 random irq");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule